// File: doc/BRIEF.md
# Nibble-Wide Dual-Port Latch RAM

This block stores 32 words of 4 bits and offers one write port and one fully independent read port. The read port is purely combinational: the stored nibble selected by the read address appears on the data output with no clock involved. The write port carries a 5-bit address, an active-low write enable and a 4-bit data word. Each of these passes through a transparent front latch before it reaches an array made of transparent storage latches.

A static mode input picks how the two latch stages are gated. In clocked mode the front latches are open while the clock is low, and the storage latches may open only while the clock is high. The pair then behaves as a rising-edge register, so a write uses the address, enable and data present at the edge. In free-running mode the front latches are always open and the load input gates the storage directly. The stored nibble then follows the data for as long as load is high and keeps the last value when load falls.

A level-sensitive clear input forces every nibble to zero and overrides any write in progress. The mode input should only change while clear is asserted.

Top module: `nibble_ram`

## Requirements
- R1: The array holds 32 independent 4-bit words; writing word a with value v and later reading address a returns v.
- R2: Read data equals the stored word at the read address combinationally, with no clock edge between an address change and the new data.
- R3: With sync_mode_i = 1, a write uses the address, data, enable and load values present at the rising edge of clk_i; changes to those inputs while clk_i is high have no effect on that write.
- R4: A write takes place only while wr_en_n_i = 0; with wr_en_n_i = 1 the addressed word keeps its contents.
- R5: A write takes place only while load_i = 1; with load_i = 0 the addressed word keeps its contents.
- R6: With sync_mode_i = 0, the addressed word follows wr_data_i while load_i = 1 and wr_en_n_i = 0, and it holds the last value after load_i falls, independent of later changes to wr_data_i.
- R7: While the addressed storage latch is open, a read of that same address returns the data being written (write-through).
- R8: While clear_i = 1 every word reads as 0, even when a write is requested at the same time; the words remain 0 after clear_i falls until written.
- R9: A write changes only the addressed word; all other words keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Write clock, used only in clocked mode |
| sync_mode_i | input | 1 | 1 selects clocked writes, 0 selects load-gated writes |
| load_i | input | 1 | Write load control, active high |
| clear_i | input | 1 | Level-sensitive clear of the whole array |
| wr_addr_i | input | 5 | Write word address |
| wr_en_n_i | input | 1 | Write enable, active low |
| wr_data_i | input | 4 | Write data |
| rd_addr_i | input | 5 | Read word address |
| rd_data_o | output | 4 | Read data, combinational from the array |

## Verification
The bench writes a distinct pattern to every address in both modes and sweeps the whole array after each step. A decoder slip or an overlapping word select therefore shows up as a wrong nibble somewhere in the sweep. In clocked mode it changes the write inputs while the clock is high. A front latch that fails to close would store the late value instead of the value present at the edge. It also opens reads onto a word while that word is being written: an array that registered its data instead of passing it through would show stale data in the high phase. Further tests block writes with the enable and with load in each mode, hold a free-running write after load falls, and request a write during clear. A wrong gate or a clear without priority leaves a nonzero or altered word in the following sweep.

// File: rtl/nram_pkg.sv
package nram_pkg;
    parameter int unsigned NRAM_AW    = 5;
    parameter int unsigned NRAM_DW    = 4;
    localparam int unsigned NRAM_WORDS = 1 << NRAM_AW;

    // Write request as seen after the front latches
    typedef struct packed {
        logic [NRAM_AW-1:0] addr;
        logic               en_n;
        logic [NRAM_DW-1:0] data;
        logic               load;
    } nram_req_t;
endpackage

// File: rtl/nram_front.sv
module nram_front
    import nram_pkg::*;
(
    input  logic               clk_i,
    input  logic               sync_mode_i,
    input  logic               load_i,
    input  logic [NRAM_AW-1:0] wr_addr_i,
    input  logic               wr_en_n_i,
    input  logic [NRAM_DW-1:0] wr_data_i,
    output nram_req_t          req_q
);
    nram_req_t req_d;
    logic      open_d;

    always_comb begin
        req_d.addr = wr_addr_i;
        req_d.en_n = wr_en_n_i;
        req_d.data = wr_data_i;
        req_d.load = load_i;
        // clocked: open during the low phase; free-running: always open
        open_d     = sync_mode_i ? ~clk_i : 1'b1;
    end

    always_latch begin
        if (open_d) begin
            req_q <= req_d;
        end
    end
endmodule

// File: rtl/nram_gate.sv
module nram_gate
    import nram_pkg::*;
(
    input  logic      clk_i,
    input  logic      sync_mode_i,
    input  nram_req_t req_i,
    output logic      gate_o
);
    logic phase_d;

    always_comb begin
        // second clock mux: clock in clocked mode, constant 1 otherwise
        phase_d = sync_mode_i ? clk_i : 1'b1;
        gate_o  = phase_d & req_i.load & ~req_i.en_n;
    end
endmodule

// File: rtl/nram_array.sv
module nram_array
    import nram_pkg::*;
(
    input  logic               clear_i,
    input  logic               gate_i,
    input  nram_req_t          req_i,
    input  logic [NRAM_AW-1:0] rd_addr_i,
    output logic [NRAM_DW-1:0] rd_data_o
);
    localparam int unsigned FLAT_W = NRAM_WORDS * NRAM_DW;

    logic [FLAT_W-1:0] flat_q;

    for (genvar w = 0; w < NRAM_WORDS; w++) begin : g_word
        logic               sel_d;
        logic               open_d;
        logic [NRAM_DW-1:0] next_d;
        logic [NRAM_DW-1:0] word_q;

        always_comb begin
            sel_d  = (req_i.addr == NRAM_AW'(w));
            open_d = clear_i | (gate_i & sel_d);
            next_d = clear_i ? '0 : req_i.data;
        end

        always_latch begin
            if (open_d) begin
                word_q <= next_d;
            end
        end

        assign flat_q[w*NRAM_DW +: NRAM_DW] = word_q;
    end

    always_comb begin
        rd_data_o = flat_q[int'(rd_addr_i)*NRAM_DW +: NRAM_DW];
    end
endmodule

// File: rtl/nibble_ram.sv
module nibble_ram
    import nram_pkg::*;
(
    input  logic               clk_i,
    input  logic               sync_mode_i,
    input  logic               load_i,
    input  logic               clear_i,
    input  logic [NRAM_AW-1:0] wr_addr_i,
    input  logic               wr_en_n_i,
    input  logic [NRAM_DW-1:0] wr_data_i,
    input  logic [NRAM_AW-1:0] rd_addr_i,
    output logic [NRAM_DW-1:0] rd_data_o
);
    nram_req_t req_q;
    logic      gate_d;

    nram_front i_front (
        .clk_i       (clk_i),
        .sync_mode_i (sync_mode_i),
        .load_i      (load_i),
        .wr_addr_i   (wr_addr_i),
        .wr_en_n_i   (wr_en_n_i),
        .wr_data_i   (wr_data_i),
        .req_q       (req_q)
    );

    nram_gate i_gate (
        .clk_i       (clk_i),
        .sync_mode_i (sync_mode_i),
        .req_i       (req_q),
        .gate_o      (gate_d)
    );

    nram_array i_array (
        .clear_i   (clear_i),
        .gate_i    (gate_d),
        .req_i     (req_q),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/nram_chk.sv
module nram_chk
    import nram_pkg::*;
(
    input logic               clk_i,
    input logic               sync_mode_i,
    input logic               load_i,
    input logic               clear_i,
    input logic [NRAM_AW-1:0] wr_addr_i,
    input logic               wr_en_n_i,
    input logic [NRAM_DW-1:0] wr_data_i,
    input logic [NRAM_AW-1:0] rd_addr_i,
    input logic [NRAM_DW-1:0] rd_data_o
);
    // R8
    clear_zero_chk: assert property (@(posedge clk_i)
        clear_i |-> rd_data_o == '0);

    // R3
    sync_write_lands_chk: assert property (@(posedge clk_i) disable iff (clear_i)
        ($past(sync_mode_i && !wr_en_n_i && load_i && !clear_i) && sync_mode_i
         && rd_addr_i == $past(wr_addr_i))
        |-> rd_data_o == $past(wr_data_i));

    // R4
    sync_idle_stable_chk: assert property (@(posedge clk_i) disable iff (clear_i)
        (sync_mode_i && $past(sync_mode_i) && !$past(clear_i)
         && ($past(wr_en_n_i) || !$past(load_i)) && $stable(rd_addr_i))
        |-> $stable(rd_data_o));

    // R7
    async_through_chk: assert property (@(posedge clk_i) disable iff (clear_i)
        (!sync_mode_i && load_i && !wr_en_n_i && rd_addr_i == wr_addr_i)
        |-> rd_data_o == wr_data_i);
endmodule

bind nibble_ram nram_chk i_chk (.*);

// File: tb/test_nibble_ram.sv
module test_nibble_ram;
    logic       clk = 1'b0;
    logic       sync_mode;
    logic       load;
    logic       clear;
    logic [4:0] wr_addr;
    logic       wr_en_n;
    logic [3:0] wr_data;
    logic [4:0] rd_addr;
    logic [3:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [32];

    nibble_ram i_nibble_ram (
        .clk_i       (clk),
        .sync_mode_i (sync_mode),
        .load_i      (load),
        .clear_i     (clear),
        .wr_addr_i   (wr_addr),
        .wr_en_n_i   (wr_en_n),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a);
            #1;
            check(req, rd_data, model[a]);
        end
    endtask

    task automatic go_idle();
        @(negedge clk); #1;
        wr_en_n = 1'b1;
        load    = 1'b0;
    endtask

    // clocked write presented during one low phase
    task automatic sync_wr(input int a, input logic [3:0] d, input logic en_n, input logic ld);
        @(negedge clk); #1;
        wr_addr = 5'(a);
        wr_data = d;
        wr_en_n = en_n;
        load    = ld;
        go_idle();
    endtask

    // free-running write: raise load, then drop it
    task automatic async_wr(input int a, input logic [3:0] d, input logic en_n);
        @(negedge clk); #1;
        wr_addr = 5'(a);
        wr_data = d;
        wr_en_n = en_n;
        #1 load = 1'b1;
        #1 load = 1'b0;
        #1 wr_en_n = 1'b1;
    endtask

    task automatic do_clear();
        @(negedge clk); #1;
        clear = 1'b1;
        repeat (2) @(negedge clk);
        #1 clear = 1'b0;
        for (int a = 0; a < 32; a++) model[a] = 4'h0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sync_mode = 1'b1;
        load      = 1'b0;
        clear     = 1'b1;
        wr_addr   = '0;
        wr_en_n   = 1'b1;
        wr_data   = '0;
        rd_addr   = '0;
        for (int a = 0; a < 32; a++) model[a] = 4'h0;
        repeat (3) @(negedge clk);
        sweep("R8 reset");
        #1 clear = 1'b0;

        // clocked sweep
        for (int a = 0; a < 32; a++) begin
            model[a] = 4'((a * 5 + 3) % 16);
            sync_wr(a, model[a], 1'b0, 1'b1);
        end
        sweep("R1 R2 clocked write");

        for (int a = 0; a < 32; a++) sync_wr(a, ~model[a], 1'b1, 1'b1);
        sweep("R4 clocked enable off");
        for (int a = 0; a < 32; a++) sync_wr(a, ~model[a], 1'b0, 1'b0);
        sweep("R5 clocked load off");

        // late change while clock high must not reach the array
        @(negedge clk); #1;
        wr_addr = 5'd4; wr_data = 4'h9; wr_en_n = 1'b0; load = 1'b1;
        @(posedge clk); #2;
        wr_addr = 5'd5; wr_data = 4'h6;
        go_idle();
        model[4] = 4'h9;
        sweep("R3 R9 edge capture");

        // read of the word under write during the high phase
        @(negedge clk); #1;
        wr_addr = 5'd10; wr_data = 4'hE; wr_en_n = 1'b0; load = 1'b1; rd_addr = 5'd10;
        #1 check("R2 old data before edge", rd_data, model[10]);
        @(posedge clk); #1;
        check("R7 clocked write-through", rd_data, 4'hE);
        go_idle();
        model[10] = 4'hE;
        sweep("R9 after write-through");

        // clear while a write is requested
        @(negedge clk); #1;
        clear = 1'b1; wr_addr = 5'd3; wr_data = 4'h7; wr_en_n = 1'b0; load = 1'b1;
        @(posedge clk); #1;
        rd_addr = 5'd3;
        #1 check("R8 clear beats write", rd_data, 4'h0);
        @(negedge clk); #1;
        wr_en_n = 1'b1; load = 1'b0;
        #1 clear = 1'b0;
        for (int a = 0; a < 32; a++) model[a] = 4'h0;
        sweep("R8 after clear");

        // free-running mode
        @(negedge clk); #1;
        clear = 1'b1; sync_mode = 1'b0;
        do_clear();
        for (int a = 0; a < 32; a++) begin
            model[a] = 4'((a * 3 + 1) % 16);
            async_wr(a, model[a], 1'b0);
        end
        sweep("R1 R6 free-running write");
        for (int a = 0; a < 32; a++) async_wr(a, ~model[a], 1'b1);
        sweep("R4 free-running enable off");
        for (int a = 0; a < 32; a++) begin
            @(negedge clk); #1;
            wr_addr = 5'(a); wr_data = ~model[a]; wr_en_n = 1'b0;
            #1 wr_en_n = 1'b1;
        end
        sweep("R5 free-running load off");

        // transparency and hold
        @(negedge clk); #1;
        wr_addr = 5'd17; rd_addr = 5'd17; wr_data = 4'h2; wr_en_n = 1'b0;
        #1 load = 1'b1;
        #1 check("R7 free-running write-through", rd_data, 4'h2);
        wr_data = 4'hB;
        #1 check("R6 follows data", rd_data, 4'hB);
        load = 1'b0;
        #1 wr_data = 4'h4;
        #1 check("R6 holds after load falls", rd_data, 4'hB);
        wr_en_n = 1'b1;
        model[17] = 4'hB;
        sweep("R9 free-running neighbours");

        // clear priority in free-running mode
        @(negedge clk); #1;
        wr_addr = 5'd8; rd_addr = 5'd8; wr_data = 4'hF; wr_en_n = 1'b0; load = 1'b1;
        clear = 1'b1;
        #1 check("R8 clear beats free-running write", rd_data, 4'h0);
        load = 1'b0; wr_en_n = 1'b1;
        #1 clear = 1'b0;
        for (int a = 0; a < 32; a++) model[a] = 4'h0;
        sweep("R8 free-running after clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule